// File: doc/BRIEF.md
# Stereo Audio Serial Output Port

This block serialises one stereo sample pair per frame onto a single data line for a converter's digital output. Each frame is 64 bit-clock periods long and is split into a left and a right slot of 32 bits. Each slot carries a 24-bit two's-complement sample, most significant bit first, followed by zero padding. A format input chooses between I2S framing and left-justified framing. A new pair is captured at the start of every frame, and a one-cycle ready pulse then asks the sample source for the following pair.

In master mode the port makes the bit clock and the frame clock itself. It divides the system clock, and a ratio select sets the system clock to 256, 384 or 512 times the sample rate. In slave mode both clocks come in from outside. They are synchronised and edge-detected in the system-clock domain, and the frame clock is sampled on bit-clock rising edges to find the channel boundaries. All logic runs on the system clock with a synchronous active-low reset.

Top module: `audio_serial_tx`

## Requirements
- R1: Each channel sample is sent as 24 bits, most significant bit first, and one bit is presented per bit-clock period.
- R2: With `fmt_i2s` = 0 (left-justified), the frame clock is high for the left slot and low for the right slot. The MSB of each sample appears in the first bit period of its slot.
- R3: With `fmt_i2s` = 1 (I2S), the frame clock is low for the left slot and high for the right slot. The MSB appears one bit period after the frame-clock transition, and the first bit period of each slot carries 0.
- R4: A frame is 64 bit periods: the first 32 form the left slot and the next 32 form the right slot.
- R5: In master mode the bit-clock period is 4, 6 or 8 system-clock cycles for `ratio_sel` 0, 1 or 2 (256, 384 or 512 times the sample rate). Value 3 behaves as 2. The high and low phases are equal.
- R6: In master mode the frame clock and the data line change only on the system-clock edge where the bit clock falls.
- R7: Every bit period in a slot that follows the 24 sample bits carries 0.
- R8: The sample pair is captured when a frame starts, and `pair_ready` pulses for one cycle at that moment, once per frame. Input changes during a frame do not alter the frame being sent.
- R9: In slave mode a frame starts on the bit-clock fall at which the frame clock enters the left level. The data line holds 0 until the first such start. New data is valid within 3 system-clock cycles of a bit-clock fall.
- R10: In slave mode `bclk_out` and `lrclk_out` are held low.
- R11: During reset, `sdata` and `pair_ready` are 0. In master mode `bclk_out` is high and `lrclk_out` sits at the right-slot level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| master_mode | input | 1 | 1: generate clocks, 0: follow external clocks |
| fmt_i2s | input | 1 | 1: I2S framing, 0: left-justified framing |
| ratio_sel | input | 2 | System-clock to sample-rate ratio: 0=256, 1=384, 2/3=512 |
| left_sample | input | 24 | Left sample, two's complement |
| right_sample | input | 24 | Right sample, two's complement |
| pair_ready | output | 1 | One-cycle pulse when a pair is captured |
| bclk_in | input | 1 | External bit clock (slave mode) |
| lrclk_in | input | 1 | External frame clock (slave mode) |
| bclk_out | output | 1 | Generated bit clock (master mode) |
| lrclk_out | output | 1 | Generated frame clock (master mode) |
| sdata | output | 1 | Serial data |

## Verification
A slot counter that is off by one or out of step shows up within one frame, either as a sample shifted by a bit position or as the frame clock changing level at the wrong bit. The frame decoder at the ports compares all 64 bit periods and the frame-clock level against the captured pair, so it catches this on the first frame that follows. A fault in the divider changes the measured bit-clock period and the spacing of `pair_ready` pulses, so it appears within two bit periods. A fault in slave boundary detection leaves the data line silent, or misaligns it, on the first frame after the frame clock starts toggling.

// File: rtl/audio_tx_pkg.sv
// Shared constants and helpers for the stereo serial output port.
// Assumes a fixed 64-bit-clock frame; the divider half-period is picked
// from the ratio select.
package audio_tx_pkg;

    typedef enum logic [1:0] {
        RATIO_256 = 2'd0,
        RATIO_384 = 2'd1,
        RATIO_512 = 2'd2
    } ratio_e;

    localparam int HALF_W = 3;

    // Half bit-clock period in system-clock cycles for a ratio select.
    function automatic logic [HALF_W-1:0] ratio_half(input logic [1:0] sel);
        case (sel)
            RATIO_256: return 3'd2;
            RATIO_384: return 3'd3;
            default:   return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/atx_master_clkgen.sv
// Master bit-clock divider. It toggles the bit clock after each half-period
// count. The count is 2, 3 or 4 system clocks, so 384x uses a divide-by-3
// count followed by a toggle. Assumes ratio_sel is held steady while running.
module atx_master_clkgen
    import audio_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic [1:0] ratio_sel,
    output logic       bclk,
    output logic       fall_evt
);
    logic [HALF_W-1:0] cnt_q;
    logic [HALF_W-1:0] half_lim;
    logic              wrap;

    assign half_lim = ratio_half(ratio_sel) - 1'b1;
    assign wrap     = (cnt_q >= half_lim);
    assign fall_evt = enable && wrap && bclk;

    // Half-period counter and bit-clock toggle; idles high when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            cnt_q <= '0;
            bclk  <= 1'b1;
        end else if (wrap) begin
            cnt_q <= '0;
            bclk  <= ~bclk;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R5
    bclk_high_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bclk) |=> $stable(bclk));
    // R5
    bclk_low_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bclk) |=> $stable(bclk));

endmodule

// File: rtl/atx_slave_sync.sv
// Slave clock front end. It brings the external bit clock and frame clock
// into the system-clock domain through two flops each, then flags bit-clock
// edges. Assumes each bit-clock phase lasts at least two system clocks.
module atx_slave_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_ext,
    input  logic lrclk_ext,
    output logic rise_evt,
    output logic fall_evt,
    output logic lr_sync
);
    logic b_s1, b_s2, b_d;
    logic lr_s1, lr_s2;

    // Two-stage synchronisers plus one delayed bit-clock copy for edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_s1  <= 1'b0;
            b_s2  <= 1'b0;
            b_d   <= 1'b0;
            lr_s1 <= 1'b0;
            lr_s2 <= 1'b0;
        end else begin
            b_s1  <= bclk_ext;
            b_s2  <= b_s1;
            b_d   <= b_s2;
            lr_s1 <= lrclk_ext;
            lr_s2 <= lr_s1;
        end
    end

    assign rise_evt = b_s2 & ~b_d;
    assign fall_evt = b_d & ~b_s2;
    assign lr_sync  = lr_s2;

    // R9
    fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_evt |=> !fall_evt);

endmodule

// File: rtl/atx_slot_shifter.sv
// Slot sequencer and serialiser. On every bit-clock fall event it advances
// a 64-position slot counter, drives the data bit for the new position and,
// in master mode, the frame-clock level. In slave mode the counter is
// re-aligned from frame-clock levels sampled at bit-clock rises. The pair is
// captured when position 0 is entered. Assumes SAMPLE_W < SLOT_W.
module atx_slot_shifter #(
    parameter int SAMPLE_W = 24,
    parameter int SLOT_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                master,
    input  logic                fmt_i2s,
    input  logic                shift_evt,
    input  logic                rise_evt,
    input  logic                lr_in,
    input  logic [SAMPLE_W-1:0] left_in,
    input  logic [SAMPLE_W-1:0] right_in,
    output logic                sdata,
    output logic                lr_level,
    output logic                pair_ready
);
    localparam int FRAME_W = 2 * SLOT_W;
    localparam int IDX_W   = $clog2(FRAME_W);
    localparam int POS_W   = $clog2(SLOT_W);

    logic [IDX_W-1:0]    slot_q, slot_n;
    logic                locked_q, locked_n;
    logic                lr_rise_q, rise_seen_q;
    logic [SAMPLE_W-1:0] left_q, right_q, word, shifted;
    logic                left_lv, bound, frame_start, bit_n;
    int                  pos, off;

    assign left_lv = ~fmt_i2s;
    assign bound   = rise_seen_q && (lr_in != lr_rise_q);

    // Next slot position and lock state for the coming bit period.
    always_comb begin
        if (!master && bound)
            slot_n = (lr_in == left_lv) ? '0 : IDX_W'(SLOT_W);
        else
            slot_n = slot_q + 1'b1;
        locked_n = master | locked_q | (!master && bound && (lr_in == left_lv));
    end

    assign frame_start = shift_evt && locked_n && (slot_n == '0);

    // Pick the sample word for the new slot and the bit at its position.
    always_comb begin
        if (slot_n[IDX_W-1])
            word = frame_start ? right_in : right_q;
        else
            word = frame_start ? left_in : left_q;
        pos     = int'(slot_n[POS_W-1:0]);
        off     = pos - (fmt_i2s ? 1 : 0);
        shifted = '0;
        bit_n   = 1'b0;
        if (!(fmt_i2s && pos == 0) && off < SAMPLE_W) begin
            shifted = word >> (SAMPLE_W - 1 - off);
            bit_n   = shifted[0];
        end
    end

    // Slot counter, data bit and frame-clock level, updated per fall event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q   <= '1;
            locked_q <= 1'b0;
            sdata    <= 1'b0;
            lr_level <= fmt_i2s;
        end else if (shift_evt) begin
            slot_q   <= slot_n;
            locked_q <= locked_n;
            sdata    <= locked_n & bit_n;
            lr_level <= slot_n[IDX_W-1] ? ~left_lv : left_lv;
        end
    end

    // Pair capture at frame start and the matching one-cycle ready pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q     <= '0;
            right_q    <= '0;
            pair_ready <= 1'b0;
        end else begin
            pair_ready <= frame_start;
            if (frame_start) begin
                left_q  <= left_in;
                right_q <= right_in;
            end
        end
    end

    // Frame-clock level sampled at bit-clock rises (slave mode only).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lr_rise_q   <= 1'b0;
            rise_seen_q <= 1'b0;
        end else if (!master && rise_evt) begin
            lr_rise_q   <= lr_in;
            rise_seen_q <= 1'b1;
        end
    end

    // R8
    pair_ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pair_ready |=> !pair_ready);
    // R7
    pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_q && int'(slot_q[POS_W-1:0]) > SAMPLE_W) |-> !sdata);
    // R6
    master_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (master && !shift_evt) |=> ($stable(lr_level) && $stable(sdata)));

endmodule

// File: rtl/audio_serial_tx.sv
// Stereo audio serial output port top. It selects master clock generation or
// slave clock following and feeds the resulting bit-clock fall events to the
// slot serialiser. Assumes mode, format and ratio change only under reset.
module audio_serial_tx #(
    parameter int SAMPLE_W = 24,
    parameter int SLOT_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                master_mode,
    input  logic                fmt_i2s,
    input  logic [1:0]          ratio_sel,
    input  logic [SAMPLE_W-1:0] left_sample,
    input  logic [SAMPLE_W-1:0] right_sample,
    output logic                pair_ready,
    input  logic                bclk_in,
    input  logic                lrclk_in,
    output logic                bclk_out,
    output logic                lrclk_out,
    output logic                sdata
);
    logic m_bclk, m_fall;
    logic s_rise, s_fall, s_lr;
    logic shift_evt, lr_level;

    atx_master_clkgen u_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (master_mode),
        .ratio_sel (ratio_sel),
        .bclk      (m_bclk),
        .fall_evt  (m_fall)
    );

    atx_slave_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk_ext  (bclk_in),
        .lrclk_ext (lrclk_in),
        .rise_evt  (s_rise),
        .fall_evt  (s_fall),
        .lr_sync   (s_lr)
    );

    assign shift_evt = master_mode ? m_fall : s_fall;

    atx_slot_shifter #(
        .SAMPLE_W (SAMPLE_W),
        .SLOT_W   (SLOT_W)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .master     (master_mode),
        .fmt_i2s    (fmt_i2s),
        .shift_evt  (shift_evt),
        .rise_evt   (s_rise),
        .lr_in      (s_lr),
        .left_in    (left_sample),
        .right_in   (right_sample),
        .sdata      (sdata),
        .lr_level   (lr_level),
        .pair_ready (pair_ready)
    );

    assign bclk_out  = master_mode & m_bclk;
    assign lrclk_out = master_mode & lr_level;

endmodule

// File: tb/sim_audio_serial_tx.sv
module sim_audio_serial_tx;
    logic        clk = 0, rst_n = 0;
    logic        master_mode = 1, fmt_i2s = 0;
    logic [1:0]  ratio_sel = 0;
    logic [23:0] left_sample = 0, right_sample = 0;
    logic        bclk_in = 0, lrclk_in = 0;
    logic        pair_ready, bclk_out, lrclk_out, sdata;

    int checks = 0, errors = 0;
    logic [47:0] sb[$];
    int frames_done = 0;
    int pair_idx = 0;

    audio_serial_tx u0 (
        .clk(clk), .rst_n(rst_n), .master_mode(master_mode), .fmt_i2s(fmt_i2s),
        .ratio_sel(ratio_sel), .left_sample(left_sample), .right_sample(right_sample),
        .pair_ready(pair_ready), .bclk_in(bclk_in), .lrclk_in(lrclk_in),
        .bclk_out(bclk_out), .lrclk_out(lrclk_out), .sdata(sdata)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [47:0] pair_of(input int k);
        logic [23:0] l, r;
        case (k % 4)
            0: begin l = 24'h800001; r = 24'h7FFFFF; end
            1: begin l = 24'hA5C3E1; r = 24'h123456; end
            2: begin l = 24'hFFFFFF; r = 24'h000001; end
            default: begin l = 24'h5A5A5A; r = 24'h800000; end
        endcase
        l = l ^ 24'(k << 9);
        r = r ^ 24'(k << 5);
        return {l, r};
    endfunction

    function automatic logic exp_bit(input logic [47:0] p, input bit i2s, input int s);
        logic [23:0] w;
        int pos, off;
        w   = (s < 32) ? p[47:24] : p[23:0];
        pos = s % 32;
        off = pos - (i2s ? 1 : 0);
        if (i2s && pos == 0) return 1'b0;
        if (off < 24) return w[23 - off];
        return 1'b0;
    endfunction

    function automatic int half_of(input logic [1:0] sel);
        return (sel == 2'd0) ? 2 : (sel == 2'd1) ? 3 : 4;
    endfunction

    // monitor state
    longint cyc = 0;
    bit mon_prev_b, mon_prev_lr, mon_coll, mon_started, rdy_prev;
    int mon_idx, pre_nonzero, pre_count, r6_viol, slave_out_hi, rdy_double;
    longint rise_t_last, bclk_period, rdy_t_last, rdy_period;
    logic prev_lr_o, prev_sd;
    logic mon_bits[64];
    logic mon_lrs[64];

    // Scoreboard compare of one decoded frame (R1 R2/R3 R4 R7 R8).
    task automatic compare_frame();
        logic [47:0] p;
        int mism;
        logic llv;
        longint a, e;
        mism = -1; a = 0; e = 0;
        llv = ~fmt_i2s;
        if (sb.size() == 0) begin
            check(0, "R8", "frame with no queued pair", 0, 1);
        end else begin
            p = sb.pop_front();
            for (int s = 0; s < 64; s++) begin
                logic eb, el;
                eb = exp_bit(p, fmt_i2s, s);
                el = (s < 32) ? llv : ~llv;
                if (mism < 0 && (mon_bits[s] !== eb || mon_lrs[s] !== el)) begin
                    mism = s;
                    a = {mon_bits[s], mon_lrs[s]};
                    e = {eb, el};
                end
            end
            check(mism < 0, fmt_i2s ? "R1 R3 R4 R7 R8" : "R1 R2 R4 R7 R8",
                  $sformatf("frame %0d slot %0d {data,lr}", frames_done, mism), a, e);
        end
        frames_done++;
    endtask

    // Monitor: decodes frames at bit-clock rises and tracks timing properties.
    always @(negedge clk) begin
        logic cb, lr, llv;
        cyc++;
        cb  = master_mode ? bclk_out : bclk_in;
        lr  = master_mode ? lrclk_out : lrclk_in;
        llv = ~fmt_i2s;
        if (!rst_n) begin
            mon_prev_b = cb; mon_prev_lr = fmt_i2s; mon_coll = 0; mon_idx = 0;
            mon_started = 0; pre_nonzero = 0; pre_count = 0; r6_viol = 0;
            slave_out_hi = 0; rdy_double = 0; rdy_prev = 0;
            rise_t_last = -1; bclk_period = 0; rdy_t_last = -1; rdy_period = 0;
        end else begin
            if (master_mode && (lrclk_out != prev_lr_o || sdata != prev_sd)
                && !(mon_prev_b && !cb)) r6_viol++;
            if (!master_mode && (bclk_out || lrclk_out)) slave_out_hi++;
            if (pair_ready) begin
                if (rdy_prev) rdy_double++;
                if (rdy_t_last >= 0) rdy_period = cyc - rdy_t_last;
                rdy_t_last = cyc;
            end
            rdy_prev = pair_ready;
            if (!mon_prev_b && cb) begin
                if (rise_t_last >= 0) bclk_period = cyc - rise_t_last;
                rise_t_last = cyc;
                if (lr == llv && mon_prev_lr != llv) begin
                    mon_coll = 1; mon_idx = 0; mon_started = 1;
                end
                if (mon_coll) begin
                    mon_bits[mon_idx] = sdata;
                    mon_lrs[mon_idx]  = lr;
                    mon_idx++;
                    if (mon_idx == 64) begin
                        compare_frame();
                        mon_coll = 0;
                    end
                end else if (!mon_started) begin
                    pre_count++;
                    if (sdata) pre_nonzero++;
                end
                mon_prev_lr = lr;
            end
        end
        mon_prev_b = cb;
        prev_lr_o  = lrclk_out;
        prev_sd    = sdata;
    end

    // Driver: on each ready pulse, scribble mid-frame, then load the next pair.
    task automatic drive_pairs(input int nfr);
        while (frames_done < nfr) begin
            @(negedge clk);
            if (pair_ready) begin
                left_sample  = 24'hDEAD00 ^ 24'(pair_idx);
                right_sample = 24'h0BEEF0 ^ 24'(pair_idx);
                repeat (6) @(negedge clk);
                pair_idx++;
                {left_sample, right_sample} = pair_of(pair_idx);
                sb.push_back(pair_of(pair_idx));
            end
        end
    endtask

    // One external bit period: fall with new frame-clock level, then rise.
    task automatic slave_bit(input logic lv);
        @(posedge clk); #2;
        bclk_in  = 0;
        lrclk_in = lv;
        repeat (4) @(posedge clk); #2;
        bclk_in = 1;
        repeat (3) @(posedge clk);
    endtask

    task automatic slave_gen(input bit i2s, input int nfr);
        logic llv;
        llv = ~i2s;
        for (int k = 0; k < 6; k++) slave_bit(~llv);
        for (int f = 0; f < nfr; f++)
            for (int s = 0; s < 64; s++) slave_bit((s < 32) ? llv : ~llv);
    endtask

    task automatic run_phase(input bit m, input bit i2s, input logic [1:0] rs, input int nfr);
        int h;
        @(negedge clk);
        rst_n = 0; master_mode = m; fmt_i2s = i2s; ratio_sel = rs;
        bclk_in = 0; lrclk_in = 0;
        sb.delete();
        frames_done = 0;
        pair_idx++;
        {left_sample, right_sample} = pair_of(pair_idx);
        sb.push_back(pair_of(pair_idx));
        repeat (4) @(negedge clk);
        // R11: reset state
        check(sdata == 0, "R11", "sdata in reset", sdata, 0);
        check(pair_ready == 0, "R11", "pair_ready in reset", pair_ready, 0);
        if (m) begin
            check(bclk_out == 1, "R11", "bclk_out in reset", bclk_out, 1);
            check(lrclk_out == i2s, "R11", "lrclk_out in reset", lrclk_out, i2s);
        end
        rst_n = 1;
        if (m) begin
            drive_pairs(nfr);
        end else begin
            fork
                slave_gen(i2s, nfr + 1);
                drive_pairs(nfr);
            join
        end
        h = half_of(rs);
        if (m) begin
            check(r6_viol == 0, "R6", "changes off bit-clock fall", r6_viol, 0);
            check(bclk_period == 2 * h, "R5", $sformatf("bclk period sel %0d", rs),
                  bclk_period, 2 * h);
            check(rdy_period == 128 * h, "R8", "pair_ready spacing", rdy_period, 128 * h);
            check(rdy_double == 0, "R8", "pair_ready width", rdy_double, 0);
        end else begin
            check(pre_count > 0, "R9", "bits seen before first frame", pre_count, 6);
            check(pre_nonzero == 0, "R9", "data before first frame", pre_nonzero, 0);
            check(slave_out_hi == 0, "R10", "clock outputs in slave", slave_out_hi, 0);
            check(rdy_double == 0, "R8", "pair_ready width slave", rdy_double, 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        run_phase(1, 0, 2'd0, 3);
        run_phase(1, 1, 2'd1, 3);
        run_phase(1, 0, 2'd2, 3);
        run_phase(1, 1, 2'd3, 3);
        run_phase(0, 1, 2'd0, 3);
        run_phase(0, 0, 2'd0, 3);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule